// File: doc/BRIEF.md
# Coalesced Interrupt Acknowledge Tracker

This block keeps score of end-of-interrupt acknowledgements for a single edge-triggered interrupt line whose deliveries must not pile up. When a delivery of the line is accepted, it records which destination processors were reached in a bitmap. It also loads a counter with the number of acknowledgements still owed. While that counter is non-zero, any fresh edge on the line is flagged as coalesced and any delivery offered to the tracker is refused. Each processor's acknowledge clears its own bit and pays off one unit of the debt. An acknowledge from a processor that was not reached is ignored.

The tracker can lose consistency, for example after a delivery that reached processors but reported failure and so left the counter at zero. If a decrement would then take the counter below zero, the tracker raises a sticky error and clears itself. It then rebuilds its bitmap and counter by visiting each processor in turn, one per clock. For each processor it reads that processor's present pending status and whether the processor matches the line's destination. The same single-processor resynchronisation step can also be requested from outside for one chosen processor. A tracker clear input empties everything and ends a rebuild at once.

Top module: `eoi_coalesce_tracker`

## Requirements
- R1: After rstN is low, owedCount is 0, outMap is 0, errSticky is 0, rebuilding is 0 and coalesced is 0.
- R2: coalesced is combinational and equals queryEdge AND (owedCount is non-zero OR rebuilding is 1).
- R3: With trkClear low, rebuilding low and owedCount zero, dlvValid loads outMap with dlvMask at the next edge. owedCount becomes the number of ones in dlvMask when dlvOk is 1, and 0 when dlvOk is 0. An accepted delivery takes precedence over an ack or sync in the same cycle.
- R4: A delivery offered while owedCount is non-zero has no effect, and an ack or sync in the same cycle is processed as if no delivery were present.
- R5: An ack (ackValid, processor number ackId) for a processor whose outMap bit is 1, with owedCount non-zero, clears that bit and decrements owedCount by one.
- R6: An ack for a processor whose outMap bit is 0 changes neither outMap nor owedCount.
- R7: trkClear overrides every other input. At the next edge owedCount, outMap and errSticky are 0 and rebuilding is 0.
- R8: An underflow sets errSticky, which stays 1 until trkClear or rstN. An underflow is an ack for a set bit while owedCount is zero, or a sync that would clear a set bit while owedCount is zero. At the same edge outMap and owedCount are cleared and rebuilding goes to 1 for exactly NUM_DEST cycles.
- R9: During a rebuild, processor i is examined at the i-th edge after the underflow (i from 0). When the rebuild ends, outMap equals the AND of the sampled pendStatus and destMatch bits, and owedCount is its population count.
- R10: A sync (syncValid, processor syncId) has the lowest priority and acts only if destMatch[syncId] is 1. If pendStatus[syncId] is 1 and the bit is clear, it sets the bit and increments owedCount. If pendStatus[syncId] is 0 and the bit is set, it clears the bit and decrements owedCount. Otherwise nothing changes.
- R11: While rebuilding is 1, dlvValid, ackValid and syncValid are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| trkClear | input | 1 | Tracker clear, highest priority |
| queryEdge | input | 1 | A new edge of the tracked line is being asked about |
| dlvValid | input | 1 | Delivery event |
| dlvOk | input | 1 | Delivery succeeded |
| dlvMask | input | NUM_DEST | Processors reached by the delivery |
| ackValid | input | 1 | Acknowledge event |
| ackId | input | IDX_W | Processor issuing the acknowledge |
| syncValid | input | 1 | Single-processor resynchronisation request |
| syncId | input | IDX_W | Processor to resynchronise |
| pendStatus | input | NUM_DEST | Current pending status per processor |
| destMatch | input | NUM_DEST | Processor matches the line's destination |
| coalesced | output | 1 | Queried edge must be treated as coalesced |
| rebuilding | output | 1 | Rebuild walk in progress |
| errSticky | output | 1 | Underflow has occurred since the last clear |
| owedCount | output | CNT_W | Acknowledgements still owed |
| outMap | output | NUM_DEST | Processors that still owe an acknowledge |

## Verification
The bench aims first at the failed-delivery path: a bitmap holds set bits while the counter is zero, and an ack or a sync-clear must then start a rebuild. A design that simply decremented would wrap the counter to its maximum and report every later edge as coalesced. The rebuild is checked edge by edge with changing pending and match inputs, so a walk that is off by one or runs too short leaves a wrong bitmap. A design that took deliveries or acks during the walk would show state the walk did not produce. Repeated acks of one processor and deliveries offered while debt remains show whether a design double-counts or overwrites live state. A clear arriving together with other events, and a clear arriving mid-walk, check that the clear really wins.

// File: rtl/eoi_trk_pkg.sv
package eoi_trk_pkg;

  // One-hot-ish set of actions the control hands to the datapath each cycle.
  typedef struct packed {
    logic clearAll;   // empty bitmap and counter
    logic markError;  // an underflow was seen, set the sticky error
    logic loadDlv;    // capture a delivery
    logic ackApply;   // apply one acknowledge
    logic stepApply;  // apply one resynchronisation step
  } trkStrobes_t;

  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_WALK = 1'b1
  } trkState_e;

endpackage

// File: rtl/eoi_trk_ctl.sv
module eoi_trk_ctl
  import eoi_trk_pkg::*;
#(
  parameter int NUM_DEST = 8,
  parameter int IDX_W    = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             trkClear,
  input  logic             dlvValid,
  input  logic             ackValid,
  input  logic             syncValid,
  input  logic [IDX_W-1:0] syncId,
  input  logic             cntZero,
  input  logic             ackUnderflow,
  input  logic             stepUnderflow,
  output trkStrobes_t      strb,
  output logic [IDX_W-1:0] stepIdx,
  output logic             busy
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_DEST - 1);

  trkState_e        state;
  logic [IDX_W-1:0] walkIdx;

  assign busy    = (state == ST_WALK);
  assign stepIdx = busy ? walkIdx : syncId;

  // Priority: clear, walk step, delivery, acknowledge, sync.
  always_comb begin
    strb = '0;
    if (trkClear) begin
      strb.clearAll = 1'b1;
    end else if (busy) begin
      strb.stepApply = 1'b1;
    end else if (dlvValid && cntZero) begin
      strb.loadDlv = 1'b1;
    end else if (ackValid) begin
      if (ackUnderflow) begin
        strb.clearAll  = 1'b1;
        strb.markError = 1'b1;
      end else begin
        strb.ackApply = 1'b1;
      end
    end else if (syncValid) begin
      if (stepUnderflow) begin
        strb.clearAll  = 1'b1;
        strb.markError = 1'b1;
      end else begin
        strb.stepApply = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      walkIdx <= '0;
    end else if (trkClear) begin
      state   <= ST_IDLE;
      walkIdx <= '0;
    end else if (busy) begin
      if (walkIdx == LAST_IDX) begin
        state   <= ST_IDLE;
        walkIdx <= '0;
      end else begin
        walkIdx <= walkIdx + 1'b1;
      end
    end else if (strb.markError) begin
      state   <= ST_WALK;
      walkIdx <= '0;
    end
  end

  // R11
  walk_blocks_events_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !(strb.loadDlv || strb.ackApply));

  // R8
  error_starts_walk_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.markError |=> busy);

  // R9
  walk_ends_on_last_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(busy) && !$past(trkClear)) |-> ($past(walkIdx) == LAST_IDX));

endmodule

// File: rtl/eoi_trk_dp.sv
module eoi_trk_dp
  import eoi_trk_pkg::*;
#(
  parameter int NUM_DEST = 8,
  parameter int IDX_W    = 3,
  parameter int CNT_W    = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  trkStrobes_t         strb,
  input  logic                dlvOk,
  input  logic [NUM_DEST-1:0] dlvMask,
  input  logic [IDX_W-1:0]    ackId,
  input  logic [IDX_W-1:0]    stepIdx,
  input  logic [NUM_DEST-1:0] pendStatus,
  input  logic [NUM_DEST-1:0] destMatch,
  output logic [CNT_W-1:0]    owedCount,
  output logic [NUM_DEST-1:0] outMap,
  output logic                errSticky,
  output logic                cntZero,
  output logic                ackUnderflow,
  output logic                stepUnderflow
);

  logic [CNT_W-1:0]    maskCount;
  logic                stepSet;
  logic                stepClr;
  logic [NUM_DEST-1:0] mapNext;
  logic [CNT_W-1:0]    cntNext;
  logic                errNext;

  // Population count of the delivery mask.
  always_comb begin
    maskCount = '0;
    for (int i = 0; i < NUM_DEST; i++) begin
      maskCount = maskCount + CNT_W'(dlvMask[i]);
    end
  end

  assign cntZero       = (owedCount == '0);
  assign ackUnderflow  = outMap[ackId] && cntZero;
  assign stepSet       = destMatch[stepIdx] && pendStatus[stepIdx] && !outMap[stepIdx];
  assign stepClr       = destMatch[stepIdx] && !pendStatus[stepIdx] && outMap[stepIdx];
  assign stepUnderflow = stepClr && cntZero;

  always_comb begin
    mapNext = outMap;
    cntNext = owedCount;
    errNext = errSticky;
    if (strb.clearAll) begin
      mapNext = '0;
      cntNext = '0;
      errNext = strb.markError;
    end else if (strb.loadDlv) begin
      mapNext = dlvMask;
      cntNext = dlvOk ? maskCount : '0;
    end else if (strb.ackApply) begin
      if (outMap[ackId]) begin
        mapNext[ackId] = 1'b0;
        cntNext        = owedCount - 1'b1;
      end
    end else if (strb.stepApply) begin
      if (stepSet) begin
        mapNext[stepIdx] = 1'b1;
        cntNext          = owedCount + 1'b1;
      end else if (stepClr) begin
        mapNext[stepIdx] = 1'b0;
        cntNext          = owedCount - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outMap    <= '0;
      owedCount <= '0;
      errSticky <= 1'b0;
    end else begin
      outMap    <= mapNext;
      owedCount <= cntNext;
      errSticky <= errNext;
    end
  end

  // R3
  count_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    owedCount <= CNT_W'(NUM_DEST));

  // R5
  ack_dec_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.ackApply && outMap[ackId] && !cntZero) |=> (owedCount == $past(owedCount) - 1'b1));

  // R6
  ack_miss_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.ackApply && !outMap[ackId]) |=> ($stable(owedCount) && $stable(outMap)));

  // R7
  clear_empty_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.clearAll |=> (owedCount == '0 && outMap == '0));

  // R8
  under_err_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.markError |=> errSticky);

  // R10
  step_inc_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.stepApply && stepSet) |=> (owedCount == $past(owedCount) + 1'b1));

endmodule

// File: rtl/eoi_coalesce_tracker.sv
module eoi_coalesce_tracker
  import eoi_trk_pkg::*;
#(
  parameter int  NUM_DEST = 8,
  localparam int IDX_W    = $clog2(NUM_DEST),
  localparam int CNT_W    = $clog2(NUM_DEST + 1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                trkClear,
  input  logic                queryEdge,
  input  logic                dlvValid,
  input  logic                dlvOk,
  input  logic [NUM_DEST-1:0] dlvMask,
  input  logic                ackValid,
  input  logic [IDX_W-1:0]    ackId,
  input  logic                syncValid,
  input  logic [IDX_W-1:0]    syncId,
  input  logic [NUM_DEST-1:0] pendStatus,
  input  logic [NUM_DEST-1:0] destMatch,
  output logic                coalesced,
  output logic                rebuilding,
  output logic                errSticky,
  output logic [CNT_W-1:0]    owedCount,
  output logic [NUM_DEST-1:0] outMap
);

  trkStrobes_t      strb;
  logic [IDX_W-1:0] stepIdx;
  logic             cntZero;
  logic             ackUnderflow;
  logic             stepUnderflow;

  eoi_trk_ctl #(.NUM_DEST(NUM_DEST), .IDX_W(IDX_W)) u_ctl (
    .clk          (clk),
    .rstN         (rstN),
    .trkClear     (trkClear),
    .dlvValid     (dlvValid),
    .ackValid     (ackValid),
    .syncValid    (syncValid),
    .syncId       (syncId),
    .cntZero      (cntZero),
    .ackUnderflow (ackUnderflow),
    .stepUnderflow(stepUnderflow),
    .strb         (strb),
    .stepIdx      (stepIdx),
    .busy         (rebuilding)
  );

  eoi_trk_dp #(.NUM_DEST(NUM_DEST), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strb         (strb),
    .dlvOk        (dlvOk),
    .dlvMask      (dlvMask),
    .ackId        (ackId),
    .stepIdx      (stepIdx),
    .pendStatus   (pendStatus),
    .destMatch    (destMatch),
    .owedCount    (owedCount),
    .outMap       (outMap),
    .errSticky    (errSticky),
    .cntZero      (cntZero),
    .ackUnderflow (ackUnderflow),
    .stepUnderflow(stepUnderflow)
  );

  assign coalesced = queryEdge && (!cntZero || rebuilding);

  // R2
  coalesce_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    (queryEdge && owedCount != '0) |-> coalesced);

endmodule

// File: tb/test_eoi_coalesce_tracker.sv
`timescale 1ns/1ps
module test_eoi_coalesce_tracker;

  localparam int ND = 8;
  localparam int IW = 3;
  localparam int CW = 4;

  logic          clk = 1'b0;
  logic          rstN;
  logic          trkClear, queryEdge, dlvValid, dlvOk, ackValid, syncValid;
  logic [ND-1:0] dlvMask, pendStatus, destMatch;
  logic [IW-1:0] ackId, syncId;
  logic          coalesced, rebuilding, errSticky;
  logic [CW-1:0] owedCount;
  logic [ND-1:0] outMap;

  int vecCount  = 0;
  int missCount = 0;
  bit doneFlag  = 0;

  // bench model state
  int          mCnt;
  logic [ND-1:0] mMap;
  logic        mErr;
  logic        mWalk;
  int          mIdx;

  always #2.5 clk = ~clk;

  eoi_coalesce_tracker #(.NUM_DEST(ND)) i_eoi_coalesce_tracker (
    .clk(clk), .rstN(rstN), .trkClear(trkClear), .queryEdge(queryEdge),
    .dlvValid(dlvValid), .dlvOk(dlvOk), .dlvMask(dlvMask),
    .ackValid(ackValid), .ackId(ackId), .syncValid(syncValid), .syncId(syncId),
    .pendStatus(pendStatus), .destMatch(destMatch),
    .coalesced(coalesced), .rebuilding(rebuilding), .errSticky(errSticky),
    .owedCount(owedCount), .outMap(outMap)
  );

  function automatic int pop8(logic [ND-1:0] v);
    int n = 0;
    for (int i = 0; i < ND; i++) n += int'(v[i]);
    return n;
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    vecCount++;
    if (act != exp) begin
      missCount++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic quietInputs();
    trkClear = 0; queryEdge = 0; dlvValid = 0; dlvOk = 0; dlvMask = '0;
    ackValid = 0; ackId = '0; syncValid = 0; syncId = '0;
    pendStatus = '0; destMatch = '0;
  endtask

  // Model one clock edge from the requirements; returns the requirement exercised.
  task automatic modelEdge(output string tag);
    int i;
    tag = "R1";
    if (trkClear) begin
      tag = "R7"; mCnt = 0; mMap = '0; mErr = 0; mWalk = 0; mIdx = 0;
    end else if (mWalk) begin
      tag = (dlvValid || ackValid || syncValid) ? "R11" : "R9";
      i = mIdx;
      if (destMatch[i] && pendStatus[i] && !mMap[i]) begin mMap[i] = 1; mCnt++; end
      else if (destMatch[i] && !pendStatus[i] && mMap[i]) begin mMap[i] = 0; mCnt--; end
      mIdx++;
      if (mIdx == ND) begin mWalk = 0; mIdx = 0; end
    end else if (dlvValid && mCnt == 0) begin
      tag = "R3"; mMap = dlvMask; mCnt = dlvOk ? pop8(dlvMask) : 0;
    end else if (ackValid) begin
      tag = dlvValid ? "R4" : "R5";
      if (mMap[ackId]) begin
        if (mCnt == 0) begin
          tag = "R8"; mErr = 1; mMap = '0; mCnt = 0; mWalk = 1; mIdx = 0;
        end else begin
          mMap[ackId] = 0; mCnt--;
        end
      end else tag = "R6";
    end else if (syncValid) begin
      tag = "R10";
      i = int'(syncId);
      if (destMatch[i] && pendStatus[i] && !mMap[i]) begin mMap[i] = 1; mCnt++; end
      else if (destMatch[i] && !pendStatus[i] && mMap[i]) begin
        if (mCnt == 0) begin
          tag = "R8"; mErr = 1; mMap = '0; mCnt = 0; mWalk = 1; mIdx = 0;
        end else begin
          mMap[i] = 0; mCnt--;
        end
      end
    end else if (dlvValid) begin
      tag = "R4";
    end
  endtask

  // Called at a falling edge with inputs already driven.
  task automatic tick();
    string tag;
    #1;
    chk("R2", "coalesced", int'(coalesced), int'(queryEdge && (mCnt != 0 || mWalk)));
    modelEdge(tag);
    @(posedge clk);
    @(negedge clk);
    chk(tag, "owedCount", int'(owedCount), mCnt);
    chk(tag, "outMap", int'(outMap), int'(mMap));
    chk(tag, "errSticky", int'(errSticky), int'(mErr));
    chk(tag, "rebuilding", int'(rebuilding), int'(mWalk));
  endtask

  task automatic finishRun();
    if (!doneFlag) begin
      doneFlag = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vecCount, missCount);
      $finish;
    end
  endtask

  initial begin
    #1_000_000;
    missCount++;
    $display("FAIL watchdog: actual running expected finished");
    finishRun();
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    quietInputs();
    rstN = 0;
    mCnt = 0; mMap = '0; mErr = 0; mWalk = 0; mIdx = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    // R1: reset state
    queryEdge = 1;
    #1;
    chk("R1", "owedCount", int'(owedCount), 0);
    chk("R1", "outMap", int'(outMap), 0);
    chk("R1", "errSticky", int'(errSticky), 0);
    chk("R1", "rebuilding", int'(rebuilding), 0);
    chk("R1", "coalesced", int'(coalesced), 0);

    // R3: full successful delivery
    quietInputs(); dlvValid = 1; dlvOk = 1; dlvMask = 8'hFF; queryEdge = 1; tick();
    // R4: second delivery refused while debt remains
    quietInputs(); dlvValid = 1; dlvOk = 1; dlvMask = 8'h01; queryEdge = 1; tick();
    // R5 then R6: repeated ack of one processor
    quietInputs(); ackValid = 1; ackId = 3; tick();
    quietInputs(); ackValid = 1; ackId = 3; tick();
    // R4 with ack in same cycle
    quietInputs(); dlvValid = 1; dlvOk = 1; dlvMask = 8'h02; ackValid = 1; ackId = 5; tick();
    // R7: clear beats delivery and ack
    quietInputs(); trkClear = 1; dlvValid = 1; dlvOk = 1; dlvMask = 8'h0F; ackValid = 1; tick();
    // R8: failed delivery leaves bits with no debt, ack underflows
    quietInputs(); dlvValid = 1; dlvOk = 0; dlvMask = 8'h0C; tick();
    quietInputs(); ackValid = 1; ackId = 2; tick();
    // R9/R11: walk with events offered that must be ignored
    for (int k = 0; k < ND; k++) begin
      quietInputs(); pendStatus = 8'hA5; destMatch = 8'h0F; queryEdge = 1;
      dlvValid = 1; dlvOk = 1; dlvMask = 8'hFF; ackValid = (k % 2 == 0); ackId = 0;
      tick();
    end
    // R8: sync-clear underflow via failed delivery, then clear mid-walk (R7)
    quietInputs(); trkClear = 1; tick();
    quietInputs(); dlvValid = 1; dlvOk = 0; dlvMask = 8'h10; tick();
    quietInputs(); syncValid = 1; syncId = 4; destMatch = 8'h10; pendStatus = 8'h00; tick();
    quietInputs(); pendStatus = 8'hFF; destMatch = 8'hFF; tick();
    quietInputs(); pendStatus = 8'hFF; destMatch = 8'hFF; tick();
    quietInputs(); trkClear = 1; tick();
    // R10: sync set on an idle tracker, unmatched sync ignored
    quietInputs(); syncValid = 1; syncId = 6; destMatch = 8'h40; pendStatus = 8'h40; tick();
    quietInputs(); syncValid = 1; syncId = 1; destMatch = 8'h00; pendStatus = 8'h02; tick();
    quietInputs(); syncValid = 1; syncId = 6; destMatch = 8'h40; pendStatus = 8'h00; tick();

    // constrained random mix
    for (int n = 0; n < 3000; n++) begin
      quietInputs();
      trkClear   = ($urandom_range(0, 99) < 2);
      queryEdge  = $urandom_range(0, 1) == 1;
      dlvValid   = ($urandom_range(0, 99) < 25);
      dlvOk      = ($urandom_range(0, 99) < 75);
      dlvMask    = ND'($urandom());
      ackValid   = ($urandom_range(0, 99) < 45);
      ackId      = IW'($urandom());
      syncValid  = ($urandom_range(0, 99) < 25);
      syncId     = IW'($urandom());
      pendStatus = ND'($urandom());
      destMatch  = ND'($urandom());
      tick();
    end
    finishRun();
  end

endmodule